// File: doc/BRIEF.md
# Multicast Forwarding Decision Unit

This unit sits in the forwarding path of a small packet switch and decides, for one memory write request at a time, which ports receive a copy of it. The request address is tested against a multicast window made of equally sized regions that start at a configured base address. Each region selects one multicast group. The ports that are members of that group receive a copy, except the port the request arrived on. Port 0 is the upstream port. When no downstream port is a member and upstream fallback is enabled, the copy goes upstream instead. When no port qualifies, the request is discarded without any error indication.

For every port the unit also gives the address that the copy of the request carries. A port with address overlay enabled replaces the bits of the address above its own split position with its overlay base. The bits below that position are kept. Requests enter through a valid/ready handshake. The decision is registered and presented one cycle after acceptance. A one-entry output register holds the decision while the consumer stalls.

Top module: `mc_fwd_decide`

## Requirements
- R1: After reset `rsp_valid` is 0 and `req_ready` is 1.
- R2: The group number is (`req_addr` − `cfg_base`) shifted right by `cfg_shift`. A request is a hit only when `req_addr` ≥ `cfg_base` and the group number is below `cfg_ngroups`. On a miss, `rsp_hit`=0, `rsp_egress`=0, `rsp_drop`=0 and every per-port address equals the request address.
- R3: On a hit, downstream port p (p ≥ 1) is in `rsp_egress` (bit p) when bit p*MAX_GROUPS+group of `cfg_member` is 1.
- R4: The ingress port never appears in `rsp_egress`.
- R5: On a hit with no downstream match, `cfg_up_en`=1 and ingress ≠ 0, `rsp_egress` is exactly 4'b0001 (port 0 only).
- R6: On a hit where no port qualifies, `rsp_drop`=1 and `rsp_egress`=0. On every other result `rsp_drop`=0.
- R7: On a hit, the address for port p is taken from `cfg_ovl_base` above bit position `cfg_ovl_size[p]` and from `req_addr` below it. The address passes through unchanged when `cfg_ovl_en[p]`=0 or `cfg_ovl_size[p]`=0.
- R8: A request is accepted when `req_valid` and `req_ready` are both 1. Its result appears with `rsp_valid`=1 after the next clock edge. `req_ready` is 1 exactly when `rsp_valid`=0 or `rsp_ready`=1. While `rsp_valid`=1 and `rsp_ready`=0, all result outputs hold their values.
- R9: The membership bits of port 0 have no effect. Port 0 receives a copy only through the fallback of R5.
- R10: Changing `cfg_shift` changes the region size. With shift 16, address base+0x3_0000 selects group 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | AW | Request address |
| req_ingress | input | PIW | Port the request arrived on |
| cfg_base | input | AW | Multicast window base |
| cfg_shift | input | SW | log2 of region size |
| cfg_ngroups | input | GW+1 | Number of groups in use |
| cfg_member | input | NPORTS*MAX_GROUPS | Group membership, bit p*MAX_GROUPS+g |
| cfg_up_en | input | 1 | Upstream fallback enable |
| cfg_ovl_en | input | NPORTS | Per-port overlay enable |
| cfg_ovl_base | input | NPORTS*AW | Per-port overlay address |
| cfg_ovl_size | input | NPORTS*SW | Per-port kept low-bit count |
| rsp_valid | output | 1 | Decision present |
| rsp_ready | input | 1 | Decision consumed |
| rsp_hit | output | 1 | Request fell in the multicast window |
| rsp_egress | output | NPORTS | Destination port mask |
| rsp_drop | output | 1 | Hit discarded silently |
| rsp_addr | output | NPORTS*AW | Per-port outgoing address |

## Verification
Ingress exclusion and upstream fallback can both act in the same decision. Removing the ingress port can leave the downstream set empty, and that is what triggers the fallback. The table drives this case in two ways. In the first, the only member is the ingress port itself. In the second, the ingress is the upstream port, so the fallback is refused and the request is dropped. The exact egress mask and the drop flag are compared in each case. A stalled response and a new acceptance also fall in the same cycle. The bench checks that the held result stays unchanged through the stall and that the next result follows right after the stall is released.

// File: rtl/mc_fwd_pkg.sv
package mc_fwd_pkg;
   typedef enum logic [1:0] {
      DEC_MISS = 2'd0,
      DEC_FWD  = 2'd1,
      DEC_DROP = 2'd2
   } mc_dec_e;
endpackage

// File: rtl/mc_grp_decode.sv
module mc_grp_decode #(
   parameter int AW         = 48,
   parameter int SW         = 6,
   parameter int MAX_GROUPS = 8,
   localparam int GW        = $clog2(MAX_GROUPS)
) (
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] base,
   input  logic [SW-1:0] shift,
   input  logic [GW:0]   ngroups,
   output logic          hit,
   output logic [GW-1:0] grp
);
   logic [AW-1:0] offs;
   logic [AW-1:0] idx;
   logic          above;
   logic          in_cfg;
   logic          in_max;

   always_comb begin
      offs   = addr - base;
      idx    = offs >> shift;
      above  = (addr >= base);
      in_cfg = (idx < AW'(ngroups));
      in_max = (idx < AW'(MAX_GROUPS));
      hit    = above && in_cfg && in_max;
      grp    = idx[GW-1:0];
   end
endmodule

// File: rtl/mc_egress_sel.sv
module mc_egress_sel
   import mc_fwd_pkg::*;
#(
   parameter int NPORTS     = 4,
   parameter int MAX_GROUPS = 8,
   parameter int UP_PORT    = 0,
   localparam int GW        = $clog2(MAX_GROUPS),
   localparam int PIW       = $clog2(NPORTS)
) (
   input  logic                         hit,
   input  logic [GW-1:0]                grp,
   input  logic [PIW-1:0]               ingress,
   input  logic [NPORTS*MAX_GROUPS-1:0] member,
   input  logic                         up_en,
   output logic [NPORTS-1:0]            egress,
   output logic                         drop,
   output mc_dec_e                      kind
);
   logic [NPORTS-1:0] dn_match;

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      if (p == UP_PORT) begin : g_up
         assign dn_match[p] = 1'b0;
      end else begin : g_dn
         logic [MAX_GROUPS-1:0] row;
         assign row         = member[p*MAX_GROUPS +: MAX_GROUPS];
         assign dn_match[p] = row[grp] && (ingress != PIW'(p));
      end
   end

   always_comb begin
      egress = '0;
      drop   = 1'b0;
      kind   = DEC_MISS;
      if (hit) begin
         if (|dn_match) begin
            egress = dn_match;
            kind   = DEC_FWD;
         end else if (up_en && (ingress != PIW'(UP_PORT))) begin
            egress[UP_PORT] = 1'b1;
            kind            = DEC_FWD;
         end else begin
            drop = 1'b1;
            kind = DEC_DROP;
         end
      end
   end
endmodule

// File: rtl/mc_overlay.sv
module mc_overlay #(
   parameter int AW = 48,
   parameter int SW = 6
) (
   input  logic          hit,
   input  logic          en,
   input  logic [AW-1:0] addr,
   input  logic [AW-1:0] ovl_base,
   input  logic [SW-1:0] size,
   output logic [AW-1:0] addr_o
);
   logic [AW-1:0] keep;

   always_comb begin
      if (32'(size) >= AW) keep = '1;
      else                 keep = (AW'(1) << size) - AW'(1);
      if (hit && en && (size != '0))
         addr_o = (ovl_base & ~keep) | (addr & keep);
      else
         addr_o = addr;
   end
endmodule

// File: rtl/mc_fwd_decide.sv
module mc_fwd_decide
   import mc_fwd_pkg::*;
#(
   parameter int NPORTS      = 4,
   parameter int AW          = 48,
   parameter int SW          = 6,
   parameter int MAX_GROUPS  = 8,
   parameter int UP_PORT     = 0,
   parameter bit HAS_OVERLAY = 1'b1,
   localparam int GW         = $clog2(MAX_GROUPS),
   localparam int PIW        = $clog2(NPORTS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   output logic                         req_ready,
   input  logic [AW-1:0]                req_addr,
   input  logic [PIW-1:0]               req_ingress,
   input  logic [AW-1:0]                cfg_base,
   input  logic [SW-1:0]                cfg_shift,
   input  logic [GW:0]                  cfg_ngroups,
   input  logic [NPORTS*MAX_GROUPS-1:0] cfg_member,
   input  logic                         cfg_up_en,
   input  logic [NPORTS-1:0]            cfg_ovl_en,
   input  logic [NPORTS*AW-1:0]         cfg_ovl_base,
   input  logic [NPORTS*SW-1:0]         cfg_ovl_size,
   output logic                         rsp_valid,
   input  logic                         rsp_ready,
   output logic                         rsp_hit,
   output logic [NPORTS-1:0]            rsp_egress,
   output logic                         rsp_drop,
   output logic [NPORTS*AW-1:0]         rsp_addr
);
   initial begin : p_param_chk
      assert (NPORTS >= 2) else $error("NPORTS must be at least 2");
      assert (MAX_GROUPS >= 2) else $error("MAX_GROUPS must be at least 2");
      assert (UP_PORT >= 0 && UP_PORT < NPORTS) else $error("UP_PORT out of range");
      assert (AW >= 8) else $error("AW too small");
      assert (SW >= 1) else $error("SW must be positive");
   end

   logic                 d_hit;
   logic [GW-1:0]        d_grp;
   logic [NPORTS-1:0]    d_egress;
   logic                 d_drop;
   mc_dec_e              d_kind;
   logic [NPORTS*AW-1:0] d_addr;
   logic                 accept;

   mc_grp_decode #(.AW(AW), .SW(SW), .MAX_GROUPS(MAX_GROUPS)) i_dec (
      .addr(req_addr), .base(cfg_base), .shift(cfg_shift),
      .ngroups(cfg_ngroups), .hit(d_hit), .grp(d_grp)
   );

   mc_egress_sel #(.NPORTS(NPORTS), .MAX_GROUPS(MAX_GROUPS), .UP_PORT(UP_PORT)) i_sel (
      .hit(d_hit), .grp(d_grp), .ingress(req_ingress), .member(cfg_member),
      .up_en(cfg_up_en), .egress(d_egress), .drop(d_drop), .kind(d_kind)
   );

   for (genvar p = 0; p < NPORTS; p++) begin : g_ovl
      if (HAS_OVERLAY) begin : g_on
         mc_overlay #(.AW(AW), .SW(SW)) i_ovl (
            .hit(d_hit), .en(cfg_ovl_en[p]), .addr(req_addr),
            .ovl_base(cfg_ovl_base[p*AW +: AW]), .size(cfg_ovl_size[p*SW +: SW]),
            .addr_o(d_addr[p*AW +: AW])
         );
      end else begin : g_off
         assign d_addr[p*AW +: AW] = req_addr;
      end
   end

   assign req_ready = !rsp_valid || rsp_ready;
   assign accept    = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_egress <= '0;
         rsp_drop   <= 1'b0;
         rsp_addr   <= '0;
      end else if (accept) begin
         rsp_valid  <= 1'b1;
         rsp_hit    <= (d_kind != DEC_MISS);
         rsp_egress <= d_egress;
         rsp_drop   <= d_drop;
         rsp_addr   <= d_addr;
      end else if (rsp_ready) begin
         rsp_valid  <= 1'b0;
      end
   end

   logic [NPORTS-1:0] ing_oh;
   assign ing_oh = NPORTS'(1) << req_ingress;

   // R4
   ingress_excluded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> ((rsp_egress & $past(ing_oh)) == '0));

   // R6
   drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !(rsp_drop && (rsp_egress != '0)));

   // R6
   drop_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_drop) |-> rsp_hit);

   // R2
   miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_egress == '0 && !rsp_drop));

   // R5
   up_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_egress[UP_PORT]) |-> ($countones(rsp_egress) == 1));

   // R8
   hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_egress)
                                     && $stable(rsp_addr) && $stable(rsp_drop)));

   // R8
   ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready == (!rsp_valid || rsp_ready));
endmodule

// File: tb/test_mc_fwd_decide.sv
module test_mc_fwd_decide;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 4;
   localparam int AW = 48;
   localparam int SW = 6;
   localparam int MG = 8;

   localparam logic [AW-1:0] BASE = 48'h0000_8000_0000;
   localparam logic [AW-1:0] OVB [NP] = '{48'h0000_C000_0000, 48'hAAAA_0000_0000,
                                          48'h1234_5670_0000, 48'h7777_0000_0000};
   localparam logic [SW-1:0] OVS [NP] = '{6'd8, 6'd16, 6'd20, 6'd0};
   localparam logic [NP-1:0] OVE = 4'b1101;

   typedef struct packed {
      logic [AW-1:0] addr;
      logic [1:0]    ing;
      logic          up;
      logic          hit;
      logic [NP-1:0] eg;
      logic          drop;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{48'h0000_8000_0010, 2'd1, 1'b1, 1'b1, 4'b1100, 1'b0},
      '{48'h0000_8000_0010, 2'd0, 1'b1, 1'b1, 4'b1110, 1'b0},
      '{48'h0000_8000_1024, 2'd0, 1'b1, 1'b1, 4'b0100, 1'b0},
      '{48'h0000_8000_1024, 2'd2, 1'b1, 1'b1, 4'b0001, 1'b0},
      '{48'h0000_8000_5008, 2'd0, 1'b1, 1'b1, 4'b0000, 1'b1},
      '{48'h0000_8000_5008, 2'd3, 1'b0, 1'b1, 4'b0000, 1'b1},
      '{48'h0000_8000_5008, 2'd3, 1'b1, 1'b1, 4'b0001, 1'b0},
      '{48'h0000_8000_4abc, 2'd1, 1'b1, 1'b1, 4'b1000, 1'b0},
      '{48'h0000_8000_6000, 2'd1, 1'b1, 1'b0, 4'b0000, 1'b0},
      '{48'h0000_7FFF_FFFC, 2'd2, 1'b1, 1'b0, 4'b0000, 1'b0},
      '{48'h0000_8000_3ff0, 2'd3, 1'b1, 1'b1, 4'b0110, 1'b0},
      '{48'h0000_8000_2100, 2'd1, 1'b1, 1'b1, 4'b0001, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [1:0] req_ingress = '0;
   logic [SW-1:0] cfg_shift = 6'd12;
   logic cfg_up_en = 1'b1;
   logic rsp_valid;
   logic rsp_ready = 1'b1;
   logic rsp_hit;
   logic [NP-1:0] rsp_egress;
   logic rsp_drop;
   logic [NP*AW-1:0] rsp_addr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // port0 bits all set (R9: ignored); port1 {0,2,3}; port2 {0,1,3}; port3 {0,3,4}
   mc_fwd_decide i_mc_fwd_decide (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_ingress(req_ingress), .cfg_base(BASE),
      .cfg_shift(cfg_shift), .cfg_ngroups(4'd6),
      .cfg_member({8'h19, 8'h0B, 8'h0D, 8'hFF}), .cfg_up_en(cfg_up_en),
      .cfg_ovl_en(OVE), .cfg_ovl_base({OVB[3], OVB[2], OVB[1], OVB[0]}),
      .cfg_ovl_size({OVS[3], OVS[2], OVS[1], OVS[0]}),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
      .rsp_egress(rsp_egress), .rsp_drop(rsp_drop), .rsp_addr(rsp_addr)
   );

   function automatic logic [AW-1:0] exp_addr(int p, logic [AW-1:0] a, logic h);
      logic [AW-1:0] m;
      if (!h || !OVE[p] || OVS[p] == '0) return a;
      m = (AW'(1) << OVS[p]) - AW'(1);
      return (OVB[p] & ~m) | (a & m);
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic send(logic [AW-1:0] a, logic [1:0] ing);
      @(negedge clk);
      req_addr    = a;
      req_ingress = ing;
      req_valid   = 1'b1;
      @(negedge clk);
      req_valid   = 1'b0;
   endtask

   task automatic check_result(string tag, logic h, logic [NP-1:0] eg, logic dr,
                               logic [AW-1:0] a);
      check({tag, " R8 valid"}, 64'(rsp_valid), 64'(1'b1));
      check({tag, " R2 hit"}, 64'(rsp_hit), 64'(h));
      check({tag, " R3 R4 R5 egress"}, 64'(rsp_egress), 64'(eg));
      check({tag, " R6 drop"}, 64'(rsp_drop), 64'(dr));
      for (int p = 0; p < NP; p++)
         check({tag, " R7 addr"}, 64'(rsp_addr[p*AW +: AW]), 64'(exp_addr(p, a, h)));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 valid in reset", 64'(rsp_valid), 64'(1'b0));
      check("R1 ready in reset", 64'(req_ready), 64'(1'b1));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 valid after reset", 64'(rsp_valid), 64'(1'b0));

      for (int i = 0; i < NV; i++) begin
         cfg_up_en = VECS[i].up;
         send(VECS[i].addr, VECS[i].ing);
         check_result($sformatf("vec%0d", i), VECS[i].hit, VECS[i].eg,
                      VECS[i].drop, VECS[i].addr);
      end
      cfg_up_en = 1'b1;

      // R10 region size follows shift: 64 KiB regions, group 3 from ingress 3
      cfg_shift = 6'd16;
      send(BASE + 48'h3_0000, 2'd3);
      check_result("R10 shift16", 1'b1, 4'b0110, 1'b0, BASE + 48'h3_0000);
      cfg_shift = 6'd12;

      // R8 stall then release while a new request waits
      @(negedge clk);
      rsp_ready = 1'b0;
      send(48'h0000_8000_4000, 2'd0);
      check("R8 ready low on stall", 64'(req_ready), 64'(1'b0));
      req_addr    = 48'h0000_8000_1000;
      req_ingress = 2'd0;
      req_valid   = 1'b1;
      repeat (2) @(negedge clk);
      check_result("R8 held", 1'b1, 4'b1000, 1'b0, 48'h0000_8000_4000);
      rsp_ready = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check_result("R8 next", 1'b1, 4'b0100, 1'b0, 48'h0000_8000_1000);
      @(negedge clk);
      check("R8 valid drains", 64'(rsp_valid), 64'(1'b0));

      done = 1'b1;
      report();
   end
endmodule